// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a half-duplex serial slave that lets an external master read and write a small byte-wide configuration register file. A transfer is framed by an active-low select line. The master first shifts in a 16-bit instruction: one read flag, two byte-count bits and a 13-bit register address. Data bytes follow. Write bytes come in on the shared data line. Read bytes go out on that same line (3-wire framing) or on a dedicated output (4-wire framing).

The serial inputs are oversampled on the chip's system clock. A synchronizer brings them into that clock domain and finds the edges of the serial clock. A controller then walks the states IDLE, INSTR, WDATA, RDATA and DONE. Its transitions are:
- any state goes to IDLE while select is high;
- IDLE goes to INSTR when select falls;
- INSTR goes to WDATA or RDATA on the 16th rising serial-clock edge, chosen by the read flag;
- WDATA or RDATA goes to DONE on the rising edge that ends the last counted byte;
- DONE waits there for select to rise.

The register at address 0 controls the port itself. Bit 0 selects 4-wire framing, bit 1 selects LSB-first data, and bit 2 requests a soft reset. Address 1 holds the burst end address. The whole register file is presented in parallel to the logic that consumes it.

Top module: `spi_cfg_slave`

## Requirements
- R1: While select is high, or after a transfer cut short by select rising before a byte completes, no register changes and sdio_oe stays low.
- R2: The instruction is always sent MSB first and is sampled on rising serial-clock edges. The first bit is the read flag (1 = read), then the count bits W1 and W0, then address bits A12 down to A0. All 13 address bits are decoded.
- R3: Count values 0, 1 and 2 transfer 1, 2 and 3 bytes. Serial clocks after the last counted byte have no effect.
- R4: Count value 3 streams until select rises. After the byte at the address held in register 1, the address returns to the transfer's start address.
- R5: A write byte is stored on its 8th rising edge, and the address then steps up by one. Addresses at or above NREG ignore writes and read as 0.
- R6: Read bits change only after falling serial-clock edges. The first bit is driven after the falling edge that follows the 16th rising edge.
- R7: In 3-wire framing (register 0 bit 0 = 0), read data appears on sdio_o with sdio_oe high through the read data phase only, and sdo stays 0.
- R8: In 4-wire framing (register 0 bit 0 = 1), read data appears on sdo, sdio_oe is never asserted, and sdo is 0 outside read data.
- R9: With register 0 bit 1 = 1, data bytes travel LSB first in both directions. The instruction is unaffected.
- R10: Writing 1 to register 0 bit 2 returns every register to its default one clock later. That bit always reads back as 0.
- R11: After reset, register 0 is 0x00, register 1 is NREG-1, and all other registers are 0x00. reg_image shows register i at bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| csb | input | 1 | Active-low transfer select |
| sclk | input | 1 | Serial clock from the master |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo | output | 1 | Dedicated read data output, always driven |
| reg_image | output | NREG*8 | Parallel view of the whole register file |

## Verification
The bench builds the block with NREG = 16 and two synchronizer stages. With this small register file, burst-end wrap-around, streams that run past the top of the file, and the 13-bit address decode (for example 0x1005 against 5) can all be reached in a handful of bytes. A serial clock of twelve system clocks per bit leaves a clear margin for the synchronizer latency. The bench checks the same register contents in both bit orders and both framings, and cross-checks every write against reg_image.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int ADDR_W     = 13;
    localparam int INSTR_BITS = 16;
    localparam int BYTE_W     = 8;

    // port control register and its fields
    localparam int CFG_ADDR   = 0;
    localparam int BEND_ADDR  = 1;
    localparam int BIT_WIRE4  = 0;
    localparam int BIT_LSB    = 1;
    localparam int BIT_SRST   = 2;

    localparam logic [1:0] W_STREAM = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } xfer_state_e;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csb_i,
    input  logic sclk_i,
    input  logic sdio_i,
    output logic csb_o,
    output logic sdi_o,
    output logic rise_o,
    output logic fall_o
);
    // bit 2 = select, bit 1 = serial clock, bit 0 = data
    localparam logic [2:0] IDLE_LINES = 3'b100;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [2:0] d;
        logic [2:0] q;
        if (i == 0) begin : g_first
            assign d = {csb_i, sclk_i, sdio_i};
        end else begin : g_next
            assign d = g_stage[i-1].q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= IDLE_LINES;
            else        q <= d;
        end
    end

    logic [2:0] lines;
    logic       sclk_d;
    assign lines = g_stage[STAGES-1].q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= lines[1];
    end

    assign csb_o  = lines[2];
    assign sdi_o  = lines[0];
    assign rise_o = lines[1] & ~sclk_d;
    assign fall_o = ~lines[1] & sclk_d;
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
    import spi_cfg_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              cfg_wire4,
    output logic              cfg_lsb,
    output logic [7:0]        burst_end,
    output logic [NREG*8-1:0] reg_image
);
    localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [7:0] SRST_MASK = ~(8'h01 << BIT_SRST);

    logic [7:0] regs [NREG];
    logic       wr_hit, rd_hit, srst;

    function automatic logic [7:0] dflt(input int idx);
        return (idx == BEND_ADDR) ? 8'(NREG - 1) : 8'h00;
    endfunction

    assign wr_hit = 32'(wr_addr) < NREG;
    assign rd_hit = 32'(rd_addr) < NREG;
    assign srst   = regs[CFG_ADDR][BIT_SRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
        end else if (srst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
        end else if (wr_en && wr_hit) begin
            regs[wr_addr[AW-1:0]] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_hit) begin
            rd_data = regs[rd_addr[AW-1:0]];
            if (rd_addr == ADDR_W'(CFG_ADDR)) rd_data = rd_data & SRST_MASK;
        end
    end

    assign cfg_wire4 = regs[CFG_ADDR][BIT_WIRE4];
    assign cfg_lsb   = regs[CFG_ADDR][BIT_LSB];
    assign burst_end = regs[BEND_ADDR];

    for (genvar g = 0; g < NREG; g++) begin : g_image
        assign reg_image[g*8 +: 8] = regs[g];
    end
endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb_s,
    input  logic              sdi_s,
    input  logic              rise,
    input  logic              fall,
    input  logic              cfg_lsb,
    input  logic [7:0]        burst_end,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              out_bit,
    output logic              out_active
);
    localparam int CNT_W = $clog2(INSTR_BITS);
    localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_BITS - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(BYTE_W - 1);

    xfer_state_e state, state_nx;

    logic [CNT_W-1:0]      cnt;
    logic [INSTR_BITS-2:0] ins_sr;
    logic [INSTR_BITS-1:0] ins_full;
    logic [1:0]            wcode, nbyte;
    logic [ADDR_W-1:0]     addr, start_addr, step_addr;
    logic [7:0]            rx, rx_full;
    logic                  bit_q;
    logic                  byte_end, instr_end, last_byte;
    logic [2:0]            sel;

    assign ins_full  = {ins_sr, sdi_s};
    assign instr_end = rise && (cnt == INSTR_LAST);
    assign byte_end  = rise && (cnt == BYTE_LAST);
    assign last_byte = (wcode != W_STREAM) && (nbyte == wcode);
    assign step_addr = ((wcode == W_STREAM) && (addr == ADDR_W'(burst_end)))
                     ? start_addr : addr + 1'b1;
    assign rx_full   = cfg_lsb ? {sdi_s, rx[7:1]} : {rx[6:0], sdi_s};
    assign sel       = cfg_lsb ? cnt[2:0] : 3'd7 - cnt[2:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (csb_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_INSTR;
                ST_INSTR: if (instr_end)
                              state_nx = ins_full[INSTR_BITS-1] ? ST_RDATA : ST_WDATA;
                ST_WDATA,
                ST_RDATA: if (byte_end && last_byte) state_nx = ST_DONE;
                ST_DONE:  state_nx = ST_DONE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            ins_sr     <= '0;
            wcode      <= 2'b00;
            nbyte      <= 2'b00;
            addr       <= '0;
            start_addr <= '0;
            rx         <= 8'h00;
            bit_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt   <= '0;
                    bit_q <= 1'b0;
                end
                ST_INSTR: if (rise) begin
                    if (cnt == INSTR_LAST) begin
                        wcode      <= ins_full[INSTR_BITS-2 -: 2];
                        addr       <= ins_full[ADDR_W-1:0];
                        start_addr <= ins_full[ADDR_W-1:0];
                        nbyte      <= 2'b00;
                        cnt        <= '0;
                    end else begin
                        ins_sr <= ins_full[INSTR_BITS-2:0];
                        cnt    <= cnt + 1'b1;
                    end
                end
                ST_WDATA, ST_RDATA: begin
                    if (rise) begin
                        rx  <= rx_full;
                        cnt <= (cnt == BYTE_LAST) ? '0 : cnt + 1'b1;
                        if (cnt == BYTE_LAST) begin
                            addr  <= step_addr;
                            nbyte <= nbyte + 1'b1;
                        end
                    end
                    if (state == ST_RDATA && fall) bit_q <= rd_data[sel];
                end
                ST_DONE: bit_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en      = (state == ST_WDATA) && byte_end && !csb_s;
        wr_data    = rx_full;
        acc_addr   = addr;
        out_bit    = bit_q;
        out_active = (state == ST_RDATA);
    end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb,
    input  logic              sclk,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo,
    output logic [NREG*8-1:0] reg_image
);
    logic              csb_s, sdi_s, sclk_rise, sclk_fall;
    logic              cfg_wire4, cfg_lsb;
    logic [7:0]        burst_end, rd_data, wr_data;
    logic [ADDR_W-1:0] acc_addr;
    logic              wr_en, out_bit, out_active;

    spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .csb_i  (csb),
        .sclk_i (sclk),
        .sdio_i (sdio_i),
        .csb_o  (csb_s),
        .sdi_o  (sdi_s),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    spi_cfg_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .csb_s      (csb_s),
        .sdi_s      (sdi_s),
        .rise       (sclk_rise),
        .fall       (sclk_fall),
        .cfg_lsb    (cfg_lsb),
        .burst_end  (burst_end),
        .rd_data    (rd_data),
        .acc_addr   (acc_addr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .out_bit    (out_bit),
        .out_active (out_active)
    );

    spi_cfg_regfile #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (acc_addr),
        .wr_data   (wr_data),
        .rd_addr   (acc_addr),
        .rd_data   (rd_data),
        .cfg_wire4 (cfg_wire4),
        .cfg_lsb   (cfg_lsb),
        .burst_end (burst_end),
        .reg_image (reg_image)
    );

    assign sdio_oe = out_active & ~cfg_wire4;
    assign sdio_o  = sdio_oe & out_bit;
    assign sdo     = cfg_wire4 & out_active & out_bit;
endmodule

// File: rtl/spi_cfg_checker.sv
module spi_cfg_checker
    import spi_cfg_pkg::*;
#(
    parameter int NREG = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csb_s,
    input logic              rise,
    input logic              fall,
    input logic              wr_en,
    input logic              out_bit,
    input logic              out_active,
    input logic              cfg_wire4,
    input logic              sdio_oe,
    input logic              sdo,
    input logic [NREG*8-1:0] reg_image
);
    p_oe_off_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (csb_s && $past(csb_s)) |-> !sdio_oe);

    p_write_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rise);

    p_bit_moves_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_active && $past(out_active) && !$stable(out_bit)) |-> $past(fall));

    p_sdo_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wire4 |-> !sdo);

    p_no_oe_wire4_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wire4 |-> !sdio_oe);

    p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_image[CFG_ADDR*8 + BIT_SRST] |=>
            (!reg_image[CFG_ADDR*8 + BIT_SRST] &&
             reg_image[BEND_ADDR*8 +: 8] == 8'(NREG - 1)));
endmodule

bind spi_cfg_slave spi_cfg_checker #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csb_s      (csb_s),
    .rise       (sclk_rise),
    .fall       (sclk_fall),
    .wr_en      (wr_en),
    .out_bit    (out_bit),
    .out_active (out_active),
    .cfg_wire4  (cfg_wire4),
    .sdio_oe    (sdio_oe),
    .sdo        (sdo),
    .reg_image  (reg_image)
);

// File: tb/spi_cfg_slave_test.sv
module spi_cfg_slave_test;
    localparam int NREG = 16;
    localparam int HALF = 6;

    logic clk = 1'b0, rst_n = 1'b0, csb = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo;
    logic [NREG*8-1:0] reg_image;

    always #4 clk = ~clk;

    spi_cfg_slave #(.NREG(NREG), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .reg_image(reg_image)
    );

    int total = 0, bad = 0, oe_err = 0;
    bit finished = 0;
    logic [7:0] mdl [NREG];
    bit m_lsb, m_wire4;
    logic [7:0] txb [8];
    logic [7:0] rxb [8];

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void mdl_reset();
        for (int i = 0; i < NREG; i++) mdl[i] = (i == 1) ? 8'(NREG - 1) : 8'h00;
        m_lsb = 1'b0;
        m_wire4 = 1'b0;
    endfunction

    function automatic logic [7:0] mdl_rd(input logic [12:0] a);
        if (32'(a) >= NREG) return 8'h00;
        if (a == 13'd0) return mdl[0] & 8'hFB;
        return mdl[a[3:0]];
    endfunction

    function automatic logic [12:0] nxt(input logic [12:0] a, input logic [12:0] st,
                                       input bit strm);
        if (strm && a == {5'd0, mdl[1]}) return st;
        return a + 13'd1;
    endfunction

    function automatic void mdl_wr(input logic [12:0] a, input logic [7:0] d);
        if (32'(a) < NREG) begin
            mdl[a[3:0]] = d;
            if (a == 13'd0) begin
                m_wire4 = d[0];
                m_lsb   = d[1];
                if (d[2]) mdl_reset();
            end
        end
    endfunction

    function automatic int eff_bytes(input logic [1:0] w, input int nbits);
        int n = nbits / 8;
        if (w != 2'd3 && n > int'(w) + 1) return int'(w) + 1;
        return n;
    endfunction

    function automatic logic [NREG*8-1:0] mdl_image();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    task automatic shift_bit(input logic b, input bit w4, input bit look, output logic r);
        sdio_i = b;
        repeat (HALF) @(negedge clk);
        r = w4 ? sdo : sdio_o;
        if (look) begin
            if (w4 ? (sdio_oe !== 1'b0) : (sdio_oe !== 1'b1 || sdo !== 1'b0)) oe_err++;
        end
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xfer(input bit rd, input logic [1:0] w, input logic [12:0] a,
                        input int nbits);
        logic [15:0] ins;
        bit lsb, w4;
        logic r;
        int eff;
        ins = {rd, w, a};
        lsb = m_lsb;
        w4  = m_wire4;
        eff = eff_bytes(w, nbits);
        oe_err = 0;
        csb = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 16; i++) shift_bit(ins[15-i], w4, 1'b0, r);
        for (int i = 0; i < nbits; i++) begin
            int j, pos;
            j = i / 8;
            pos = lsb ? (i % 8) : 7 - (i % 8);
            shift_bit(rd ? 1'b0 : txb[j][pos], w4, rd && (j < eff), r);
            rxb[j][pos] = r;
        end
        repeat (HALF) @(negedge clk);
        csb = 1'b1;
        sdio_i = 1'b0;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] w, input logic [12:0] a, input int nbits);
        logic [12:0] cur;
        xfer(1'b0, w, a, nbits);
        cur = a;
        for (int b = 0; b < eff_bytes(w, nbits); b++) begin
            mdl_wr(cur, txb[b]);
            cur = nxt(cur, a, w == 2'd3);
        end
    endtask

    task automatic do_read(input logic [1:0] w, input logic [12:0] a, input int nbits,
                           input string req);
        logic [12:0] cur;
        bit w4;
        w4 = m_wire4;
        xfer(1'b1, w, a, nbits);
        cur = a;
        for (int b = 0; b < eff_bytes(w, nbits); b++) begin
            chk(req, "read byte", rxb[b], mdl_rd(cur));
            cur = nxt(cur, a, w == 2'd3);
        end
        chk(w4 ? "R8" : "R7", "line enables during read", oe_err, 0);
    endtask

    task automatic set_reg(input logic [12:0] a, input logic [7:0] d);
        txb[0] = d;
        do_write(2'd0, a, 8);
    endtask

    task automatic check_image(input string req);
        chk(req, "reg_image", reg_image, mdl_image());
    endtask

    initial begin
        void'($urandom(32'd20240611));
        mdl_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11 reset state, R1 idle lines
        check_image("R11");
        chk("R1", "sdio_oe idle", sdio_oe, 1'b0);
        chk("R7", "sdo idle", sdo, 1'b0);
        do_read(2'd1, 13'd0, 16, "R11");

        // R3 single-byte write with trailing clocks
        txb[0] = 8'hA5; txb[1] = 8'hFF;
        do_write(2'd0, 13'd5, 16);
        check_image("R3");
        do_read(2'd0, 13'd5, 16, "R3");

        // R5 multi-byte counted writes
        txb[0] = 8'h12; txb[1] = 8'h34;
        do_write(2'd1, 13'd3, 16);
        txb[0] = 8'h56; txb[1] = 8'h78; txb[2] = 8'h9A;
        do_write(2'd2, 13'd10, 24);
        check_image("R5");
        do_read(2'd2, 13'd10, 24, "R5");

        // R1 aborted transfer
        txb[0] = 8'h3C;
        do_write(2'd0, 13'd7, 4);
        check_image("R1");

        // R5 out-of-range, R2 full address decode
        set_reg(13'd200, 8'hEE);
        set_reg(13'h1005, 8'h77);
        check_image("R2");
        do_read(2'd0, 13'd200, 8, "R5");

        // R4 stream with burst end wrap
        set_reg(13'd1, 8'd9);
        txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33; txb[3] = 8'h44; txb[4] = 8'h55;
        do_write(2'd3, 13'd7, 40);
        check_image("R4");
        do_read(2'd3, 13'd7, 48, "R4");

        // R9 LSB-first data
        set_reg(13'd0, 8'h02);
        set_reg(13'd4, 8'h01);
        check_image("R9");
        do_read(2'd0, 13'd4, 8, "R9");

        // R8 four-wire framing, both orders
        set_reg(13'd0, 8'h03);
        do_read(2'd2, 13'd3, 24, "R8");
        set_reg(13'd0, 8'h01);
        do_read(2'd0, 13'd4, 8, "R8");
        chk("R8", "sdo idle in 4-wire", sdo, 1'b0);
        chk("R8", "sdio_oe idle in 4-wire", sdio_oe, 1'b0);
        set_reg(13'd0, 8'h00);
        chk("R7", "sdo quiet in 3-wire", sdo, 1'b0);

        // random mix across modes
        for (int it = 0; it < 40; it++) begin
            logic [12:0] a;
            logic [1:0] w;
            int nb, nbits;
            if (it % 8 == 0) begin
                set_reg(13'd1, 8'(2 + $urandom % (NREG - 2)));
                set_reg(13'd0, 8'($urandom % 4));
            end
            a = 13'(2 + $urandom % (NREG - 2));
            w = 2'($urandom % 4);
            nb = (w == 2'd3) ? 1 + int'($urandom % 5) : int'(w) + 1;
            for (int b = 0; b < 8; b++) txb[b] = 8'($urandom);
            nbits = nb * 8 + ((w != 2'd3 && ($urandom % 2) == 1) ? 8 : 0);
            do_write(w, a, nbits);
            check_image(w == 2'd3 ? "R4" : "R5");
            do_read(w, a, nbits, m_lsb ? "R9" : "R6");
        end

        // R10 soft reset
        set_reg(13'd0, 8'h00);
        set_reg(13'd6, 8'h5A);
        set_reg(13'd0, 8'h06);
        check_image("R10");
        do_read(2'd0, 13'd0, 8, "R10");
        do_read(2'd0, 13'd6, 8, "R10");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule